// File: doc/BRIEF.md
# Push-Button Power Sequencer

This block turns a single push-button into a controlled board power cycle. It filters the raw button level through a synchronizer and a saturating-count debouncer, then runs a four-state handshake: off, ignition, on and shutdown. A filtered press while off raises the power enable and waits for the main supply to report good. A later press, made only after the button has been let go once while on, pulls the active-low shutdown request to the processor low. The block then waits for the main supply to fall before dropping the power enable and going back to off.

Alongside the sequencer, the block steers the memory supply: a select input picks either the main power-good level or the standby power-good level, and both true and inverted copies are driven out. The oscillator enable mirrors main power-good. These three outputs are combinational from the pins, so they stay correct even while the slow clock is stopped. The reset is asynchronous and active low, and is released on a clock edge.

Top module: `pwr_sequencer`

## Requirements
- R1: While reset is low, and after its release with the button released, `pwr_en` reads 0 and `batt_irq_n` reads 1.
- R2: In off, a filtered press drives `pwr_en` to 1. With default parameters `pwr_en` rises at the 19th rising edge after the raw button goes high: 2 synchronizer stages, 16 debounce edges and 1 state edge.
- R3: In ignition, button activity of any length has no effect: `pwr_en` stays 1 and `batt_irq_n` stays 1 until `main_pgood` has been seen high.
- R4: In on, a button held since before entering on does nothing. Once a filtered release has been seen, a filtered press drives `batt_irq_n` to 0 at the 19th rising edge after the raw press, with `pwr_en` still 1.
- R5: In shutdown, `pwr_en` stays 1 and `batt_irq_n` stays 0, whatever the button does, while `main_pgood` is 1. At the 3rd rising edge after `main_pgood` falls, `pwr_en` becomes 0 and `batt_irq_n` becomes 1.
- R6: The filtered button level changes only after the synchronized raw level has differed from it on 16 consecutive edges. Any edge where they agree clears the count, so a 15-cycle press has no effect.
- R7: The filtered level is seeded from the raw button on the first edge after reset release, without a debounce wait. With the button held through reset, `pwr_en` is 0 three edges after release and 1 at the 4th edge.
- R8: `mem_pwr` equals `main_pgood` when `mem_sel_stby` is 0 and `stby_pgood` when it is 1. `mem_pwr_n` is always its inverse. Both follow the pins with no clock.
- R9: `osc_en` equals `main_pgood` at all times, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow local oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| btn_raw | input | 1 | Raw power button, 1 = pressed |
| main_pgood | input | 1 | Main supply good |
| stby_pgood | input | 1 | Standby supply good |
| mem_sel_stby | input | 1 | Memory supply select: 0 = main, 1 = standby |
| pwr_en | output | 1 | Main power enable |
| batt_irq_n | output | 1 | Active-low shutdown request to the processor |
| mem_pwr | output | 1 | Selected memory power level |
| mem_pwr_n | output | 1 | Inverse of mem_pwr |
| osc_en | output | 1 | Oscillator enable |

## Verification
The sequencer is driven through a full power cycle. Presses are timed to the exact edge so that the debounce length and the pipeline depth are pinned down in both the off-to-ignition and on-to-shutdown directions. A 15-cycle pulse separates a correct 16-edge filter from a shorter or non-clearing one. A button held across ignition and into on, and a re-press during ignition, separate a design that waits for power-good and a release from one that simply toggles on every press. A button held through reset shows whether the filter is seeded or debounced from zero. The supply-select outputs are tried with every combination of select, main and standby levels, which exposes a swapped or inverted path.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    PS_OFF      = 2'd0,
    PS_IGNITE   = 2'd1,
    PS_ON       = 2'd2,
    PS_SHUTDOWN = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwrseq_sync.sv
// Multi-bit level synchronizer; the flops carry no reset so they track the
// pins during reset as well.
module pwrseq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pwrseq_rst_sync.sv
// Asynchronous assert, clocked release of the active-low reset.
module pwrseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/pwrseq_debounce.sv
// Holds a filtered level that moves only after the input has disagreed with
// it on 2**CNT_W consecutive edges. Seeded from the input after reset.
module pwrseq_debounce #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_in,
  output logic             level_out,
  output logic             level_valid,
  output logic [CNT_W-1:0] settle_cnt
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic             filt_q, filt_d;
  logic             seed_q, seed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             differ, full, upd_en;

  assign differ = (level_in != filt_q);
  assign full   = (cnt_q == CntMax);
  // Registers only move when seeding, counting or clearing a count.
  assign upd_en = !seed_q || differ || (cnt_q != '0);

  always_comb begin
    filt_d = filt_q;
    seed_d = seed_q;
    cnt_d  = cnt_q;
    if (!seed_q) begin
      filt_d = level_in;
      seed_d = 1'b1;
      cnt_d  = '0;
    end else if (differ) begin
      if (full) begin
        filt_d = level_in;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      seed_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      filt_q <= filt_d;
      seed_q <= seed_d;
      cnt_q  <= cnt_d;
    end
  end

  assign level_out   = filt_q;
  assign level_valid = seed_q;
  assign settle_cnt  = cnt_q;
endmodule

// File: rtl/pwrseq_fsm.sv
// Ignition / shutdown handshake. In the on state a release must be seen
// (armed) before a press is taken as a shutdown request.
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic press,
  input  logic pgood,
  output logic pwr_en,
  output logic batt_irq_n
);
  pwr_state_e state_q, state_d;
  logic       armed_q, armed_d;
  logic       st_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_OFF:      if (press)            state_d = PS_IGNITE;
      PS_IGNITE:   if (pgood)            state_d = PS_ON;
      PS_ON:       if (armed_q && press) state_d = PS_SHUTDOWN;
      PS_SHUTDOWN: if (!pgood)           state_d = PS_OFF;
      default:                           state_d = PS_OFF;
    endcase
    armed_d = (state_d == PS_ON) &&
              (armed_q || ((state_q == PS_ON) && !press));
  end

  assign st_en = (state_d != state_q) || (armed_d != armed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OFF;
      armed_q <= 1'b0;
    end else if (st_en) begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  assign pwr_en     = (state_q != PS_OFF);
  assign batt_irq_n = (state_q != PS_SHUTDOWN);
endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer #(
  parameter int DEB_BITS    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  input  logic main_pgood,
  input  logic stby_pgood,
  input  logic mem_sel_stby,
  output logic pwr_en,
  output logic batt_irq_n,
  output logic mem_pwr,
  output logic mem_pwr_n,
  output logic osc_en
);
  logic                srst_n;
  logic [1:0]          sync_q;
  logic                btn_s, pgood_s;
  logic                sw_filt, filt_valid;
  logic [DEB_BITS-1:0] settle_cnt;

  pwrseq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pwrseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({main_pgood, btn_raw}),
    .q   (sync_q)
  );
  assign btn_s   = sync_q[0];
  assign pgood_s = sync_q[1];

  pwrseq_debounce #(.CNT_W(DEB_BITS)) u_deb (
    .clk         (clk),
    .rst_n       (srst_n),
    .level_in    (btn_s),
    .level_out   (sw_filt),
    .level_valid (filt_valid),
    .settle_cnt  (settle_cnt)
  );

  pwrseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (srst_n),
    .press      (sw_filt && filt_valid),
    .pgood      (pgood_s),
    .pwr_en     (pwr_en),
    .batt_irq_n (batt_irq_n)
  );

  // Supply steering stays clock-free: the clock source itself is gated by osc_en.
  assign mem_pwr   = mem_sel_stby ? stby_pgood : main_pgood;
  assign mem_pwr_n = !mem_pwr;
  assign osc_en    = main_pgood;
endmodule

// File: rtl/pwr_sequencer_chk.sv
module pwr_sequencer_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_en,
  input logic             batt_irq_n,
  input logic             sw_filt,
  input logic             filt_valid,
  input logic [CNT_W-1:0] settle_cnt,
  input logic             pgood_s
);
  localparam logic [CNT_W-1:0] CntTop = '1;

  // R2: power enable only rises after a filtered press was seen
  p_rise_after_press_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> $past(sw_filt && filt_valid));

  // R4: shutdown request needs a filtered press while powered
  p_shutdown_needs_press_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(batt_irq_n) |-> ($past(sw_filt) && $past(pwr_en)));

  // R5: power drops only once power-good has gone low
  p_drop_needs_pgood_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> !$past(pgood_s));

  // R5: the shutdown request is released together with power off
  p_batt_release_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(batt_irq_n) |-> !pwr_en);

  // R6: a settled filter level moves only from a full count
  p_filter_full_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(filt_valid) && (sw_filt != $past(sw_filt))) |-> ($past(settle_cnt) == CntTop));
endmodule

bind pwr_sequencer pwr_sequencer_chk #(.CNT_W(DEB_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_en     (pwr_en),
  .batt_irq_n (batt_irq_n),
  .sw_filt    (sw_filt),
  .filt_valid (filt_valid),
  .settle_cnt (settle_cnt),
  .pgood_s    (pgood_s)
);

// File: tb/test_pwr_sequencer.sv
`timescale 1ns/1ps
module test_pwr_sequencer;
  logic clk = 1'b0;
  logic rst_n, btn_raw, main_pgood, stby_pgood, mem_sel_stby;
  logic pwr_en, batt_irq_n, mem_pwr, mem_pwr_n, osc_en;

  always #10 clk = !clk;  // 50 MHz

  pwr_sequencer i_pwr_sequencer (
    .clk          (clk),
    .rst_n        (rst_n),
    .btn_raw      (btn_raw),
    .main_pgood   (main_pgood),
    .stby_pgood   (stby_pgood),
    .mem_sel_stby (mem_sel_stby),
    .pwr_en       (pwr_en),
    .batt_irq_n   (batt_irq_n),
    .mem_pwr      (mem_pwr),
    .mem_pwr_n    (mem_pwr_n),
    .osc_en       (osc_en)
  );

  typedef struct {
    string      tag;
    logic [4:0] exp;
  } sb_item_t;

  sb_item_t q[$];
  event     sample_ev;
  int       vectors = 0;
  int       miscompares = 0;
  bit       done = 1'b0;

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    forever begin
      @(sample_ev);
      #1;
      while (q.size() > 0) begin
        sb_item_t it;
        logic [4:0] act;
        it  = q.pop_front();
        act = {pwr_en, batt_irq_n, mem_pwr, mem_pwr_n, osc_en};
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s: actual {pwr,batt_n,mem,mem_n,osc}=%b expected %b",
                   it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic steps(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Driver side: expected supply outputs are derived from the pins (R8, R9).
  task automatic expect_out(input string tag, input logic e_pwr, input logic e_batt);
    sb_item_t it;
    logic e_mem;
    e_mem  = mem_sel_stby ? stby_pgood : main_pgood;
    it.tag = tag;
    it.exp = {e_pwr, e_batt, e_mem, !e_mem, main_pgood};
    q.push_back(it);
    -> sample_ev;
    #3;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; btn_raw = 1'b0; main_pgood = 1'b0;
    stby_pgood = 1'b0; mem_sel_stby = 1'b0;
    steps(3);
    expect_out("R1 in reset", 1'b0, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    steps(6);
    expect_out("R1 after reset", 1'b0, 1'b1);

    // R8 / R9: supply steering over every pin combination
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {mem_sel_stby, main_pgood, stby_pgood} = v[2:0];
      #2;
      expect_out($sformatf("R8 R9 select pattern %0d", v), 1'b0, 1'b1);
    end
    @(negedge clk) {mem_sel_stby, main_pgood, stby_pgood} = 3'b000;
    steps(5);

    // R6: a 15-cycle pulse is filtered out
    @(negedge clk) btn_raw = 1'b1;
    repeat (15) @(posedge clk);
    @(negedge clk) btn_raw = 1'b0;
    steps(30);
    expect_out("R6 short pulse ignored", 1'b0, 1'b1);

    // R2: ignition at exactly the 19th edge
    @(negedge clk) btn_raw = 1'b1;
    steps(18);
    expect_out("R2 not yet at edge 18", 1'b0, 1'b1);
    steps(1);
    expect_out("R2 power on at edge 19", 1'b1, 1'b1);

    // R3: ignition ignores the button while power-good is low
    @(negedge clk) btn_raw = 1'b0;
    steps(40);
    expect_out("R3 release in ignition", 1'b1, 1'b1);
    @(negedge clk) btn_raw = 1'b1;
    steps(40);
    expect_out("R3 press in ignition ignored", 1'b1, 1'b1);

    // R4: held button after power-good does not shut down
    @(negedge clk) main_pgood = 1'b1;
    steps(40);
    expect_out("R4 held button not a request", 1'b1, 1'b1);
    @(negedge clk) btn_raw = 1'b0;
    steps(40);
    expect_out("R4 release arms", 1'b1, 1'b1);
    @(negedge clk) btn_raw = 1'b1;
    steps(18);
    expect_out("R4 no request at edge 18", 1'b1, 1'b1);
    steps(1);
    expect_out("R4 request at edge 19", 1'b1, 1'b0);

    // R5: shutdown holds until power-good drops
    @(negedge clk) btn_raw = 1'b0;
    steps(40);
    expect_out("R5 shutdown held", 1'b1, 1'b0);
    @(negedge clk) btn_raw = 1'b1;
    steps(40);
    expect_out("R5 press in shutdown ignored", 1'b1, 1'b0);
    @(negedge clk) btn_raw = 1'b0;
    steps(40);
    @(negedge clk) main_pgood = 1'b0;
    steps(2);
    expect_out("R5 still on at edge 2", 1'b1, 1'b0);
    steps(1);
    expect_out("R5 off at edge 3", 1'b0, 1'b1);
    steps(30);
    expect_out("R5 stays off", 1'b0, 1'b1);

    // R7: button held through reset is seeded, no debounce wait
    @(negedge clk) begin rst_n = 1'b0; btn_raw = 1'b1; end
    steps(4);
    expect_out("R1 reset with button held", 1'b0, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    steps(3);
    expect_out("R7 off three edges after release", 1'b0, 1'b1);
    steps(1);
    expect_out("R7 seeded ignition at edge 4", 1'b1, 1'b1);

    steps(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule